// File: doc/BRIEF.md
# SPI Register Access Port

This block is a serial slave that lets an off-chip host read and write a bank of 256 byte-wide configuration registers over a four-wire serial link. The link uses an active-low select, a serial clock that idles low, a host-to-device data line and a device-to-host data line.

Each select-low window carries three parts in order: an opcode byte, an 8-bit register address, and then any number of data bytes. Write bursts and read bursts step through consecutive register addresses. The register bank itself is outside the block. The block drives it through a one-cycle write strobe with address and data, and through a read address whose data must come back combinationally in the same cycle.

All serial inputs are treated as already synchronous to `clk`. Each serial clock level must be held for at least two `clk` cycles. The register side has no back-pressure: there is no ready signal, so the bank must accept a write strobe in any cycle and must return read data without wait states.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, and until a transaction begins, `sdo` is 0 and `wr_en` is 0.
- R2: The opcode 8'h02, then an address byte, then a data byte (each MSB first, bits taken on rising `sclk`) produces exactly one `wr_en` pulse one `clk` cycle wide, with `wr_addr` equal to the address and `wr_data` equal to the data byte.
- R3: In a write burst, byte k (counting from 0) is written to address+k modulo 256, so 8'hFF is followed by 8'h00.
- R4: After the opcode 8'h03 and an address byte, `sdo` presents the register at that address MSB first. Bit 7 appears after the falling `sclk` edge that follows the 16th rising edge, and the next bit after each later falling edge.
- R5: In a read burst, byte k returns the register at address+k modulo 256, with wrap from 8'hFF to 8'h00.
- R6: An opcode other than 8'h02 or 8'h03 makes the rest of the window inert: no `wr_en` pulse occurs and `sdo` stays 0.
- R7: In a write, a data byte cut short by `cs_n` rising produces no write. Earlier complete bytes of the same burst are still written.
- R8: During a read, the bits on `sdi` after the address byte have no effect: no write occurs and the returned bytes do not depend on them.
- R9: While selected, `sdo` changes only on falling `sclk`. Once `cs_n` is high, `sdo` returns to 0.
- R10: Raising `cs_n` mid-byte discards the bits already received, so the next window starts with a fresh opcode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all serial inputs are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low transaction select |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register write address |
| wr_data | output | 8 | Register write data |
| rd_addr | output | 8 | Register read address (burst pointer) |
| rd_data | input | 8 | Register read data, valid in the same cycle as `rd_addr` |

## Verification
A wrong bit count or phase shows up at the port within one byte. Writes appear at a shifted address or carry a rotated value, and read data on `sdo` comes out shifted by one or more positions. A pointer that fails to advance shows up on the second byte of any burst. A wrap fault only shows up on a burst that crosses 8'hFF, so both a write burst and a read burst are started near the top of the map. A stale phase after an aborted window shows up on the first strobe of the next window: it is either missing or lands at the wrong address.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int unsigned WORD_W = 8;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_WRITE,
    PH_READ,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_edge_det.sv
module spi_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_i;
  end

  assign rise_o = sclk_i & ~sclk_q;
  assign fall_o = ~sclk_i & sclk_q;
endmodule

// File: rtl/spi_rx_deser.sv
module spi_rx_deser #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active_i,
  input  logic         rise_i,
  input  logic         sdi_i,
  output logic         boundary_o,
  output logic         done_o,
  output logic [W-1:0] word_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (!active_i) begin
      cnt_q <= '0;
    end else if (rise_i) begin
      sh_q  <= {sh_q[W-2:0], sdi_i};
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign boundary_o = (cnt_q == '0);
  assign done_o     = active_i & rise_i & (cnt_q == LAST);
  assign word_o     = {sh_q[W-2:0], sdi_i};

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> boundary_o); // R10
endmodule

// File: rtl/spi_tx_ser.sv
module spi_tx_ser #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active_i,
  input  logic         fall_i,
  input  logic         send_i,
  input  logic         boundary_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  output logic         sdo_o
);
  logic [W-1:0] stage_q;
  logic [W-1:0] sh_q;
  logic         sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      sh_q    <= '0;
      sdo_q   <= 1'b0;
    end else begin
      if (load_i) stage_q <= load_data_i;
      if (!active_i) begin
        sdo_q <= 1'b0;
      end else if (fall_i) begin
        if (!send_i) begin
          sdo_q <= 1'b0;
        end else if (boundary_i) begin
          sdo_q <= stage_q[W-1];
          sh_q  <= {stage_q[W-2:0], 1'b0};
        end else begin
          sdo_q <= sh_q[W-1];
          sh_q  <= {sh_q[W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo_o = sdo_q;

  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !fall_i) |=> $stable(sdo_q)); // R9
  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> !sdo_q); // R9
  AST_SDO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && fall_i && !send_i) |=> !sdo_q); // R6
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
  parameter int unsigned W     = spi_reg_pkg::WORD_W,
  parameter logic [W-1:0] WR_OP = W'(8'h02),
  parameter logic [W-1:0] RD_OP = W'(8'h03)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         sdi,
  output logic         sdo,
  output logic         wr_en,
  output logic [W-1:0] wr_addr,
  output logic [W-1:0] wr_data,
  output logic [W-1:0] rd_addr,
  input  logic [W-1:0] rd_data
);
  import spi_reg_pkg::*;

  logic         active;
  logic         rise, fall;
  logic         boundary, done;
  logic [W-1:0] word;

  phase_t       ph_q;
  logic         is_rd_q;
  logic         fetch_q;
  logic [W-1:0] ptr_q;
  logic         wr_en_q;
  logic [W-1:0] wr_addr_q, wr_data_q;

  assign active = ~cs_n;

  spi_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_i (sclk),
    .rise_o (rise),
    .fall_o (fall)
  );

  spi_rx_deser #(.W(W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (active),
    .rise_i     (rise),
    .sdi_i      (sdi),
    .boundary_o (boundary),
    .done_o     (done),
    .word_o     (word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_OPCODE;
      is_rd_q   <= 1'b0;
      fetch_q   <= 1'b0;
      ptr_q     <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      fetch_q <= 1'b0;
      if (!active) begin
        ph_q <= PH_OPCODE;
      end else begin
        if (fetch_q) ptr_q <= ptr_q + 1'b1;
        if (done) begin
          unique case (ph_q)
            PH_OPCODE: begin
              if (word == WR_OP) begin
                is_rd_q <= 1'b0;
                ph_q    <= PH_ADDR;
              end else if (word == RD_OP) begin
                is_rd_q <= 1'b1;
                ph_q    <= PH_ADDR;
              end else begin
                ph_q    <= PH_SKIP;
              end
            end
            PH_ADDR: begin
              ptr_q <= word;
              if (is_rd_q) begin
                ph_q    <= PH_READ;
                fetch_q <= 1'b1;
              end else begin
                ph_q    <= PH_WRITE;
              end
            end
            PH_WRITE: begin
              wr_en_q   <= 1'b1;
              wr_addr_q <= ptr_q;
              wr_data_q <= word;
              ptr_q     <= ptr_q + 1'b1;
            end
            PH_READ:  fetch_q <= 1'b1;
            default:  ;
          endcase
        end
      end
    end
  end

  spi_tx_ser #(.W(W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active),
    .fall_i      (fall),
    .send_i      (ph_q == PH_READ),
    .boundary_i  (boundary),
    .load_i      (fetch_q),
    .load_data_i (rd_data),
    .sdo_o       (sdo)
  );

  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign rd_addr = ptr_q;

  AST_WR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> $past(ph_q == PH_WRITE)); // R2
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> (ptr_q == wr_addr_q + 1'b1)); // R3
  AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SKIP) |-> !wr_en_q); // R6
  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_READ) |-> !wr_en_q); // R8
endmodule

// File: tb/spi_reg_port_tb.sv
module spi_reg_port_tb;
  localparam int HALF = 4;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] addr;
    logic [7:0] nb;
    logic [7:0] seed;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h02, 8'h10, 8'd1, 8'h3C},
    '{8'h02, 8'hFE, 8'd4, 8'h80},
    '{8'h03, 8'h10, 8'd1, 8'hFF},
    '{8'h03, 8'hFD, 8'd5, 8'h5A},
    '{8'h07, 8'h20, 8'd2, 8'hC3},
    '{8'h03, 8'h40, 8'd3, 8'hA5},
    '{8'h02, 8'h80, 8'd2, 8'hC1},
    '{8'h00, 8'h81, 8'd2, 8'h99}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

  always #5 clk = ~clk;

  spi_reg_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  logic [7:0] mem [256];
  logic [7:0] log_a [512];
  logic [7:0] log_d [512];
  int log_n = 0;

  assign rd_data = mem[rd_addr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
      log_a[log_n] <= wr_addr;
      log_d[log_n] <= wr_data;
      log_n <= log_n + 1;
    end
  end

  int checks = 0, errors = 0;
  int glitch = 0;
  logic sdo_any = 1'b0;
  logic finished = 1'b0;
  logic [7:0] shadow [256];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    logic pre;
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      sdi = tx[7-i];
      repeat (HALF) @(negedge clk);
      pre = sdo;
      rx = {rx[6:0], sdo};
      sdo_any = sdo_any | sdo;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (sdo !== pre) glitch++;
      sclk = 1'b0;
    end
  endtask

  task automatic sel_on();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel_off();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    int base;
    for (int i = 0; i < 256; i++) shadow[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    chk("R1 sdo at reset", 32'(sdo), 0);
    chk("R1 wr_en at reset", 32'(wr_en), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 sdo idle", 32'(sdo), 0);
    chk("R1 wr_en idle", 32'(wr_en), 0);

    for (int v = 0; v < NV; v++) begin
      base = log_n;
      glitch = 0;
      sdo_any = 1'b0;
      sel_on();
      spi_bits(VECS[v].cmd, 8, rx);
      spi_bits(VECS[v].addr, 8, rx);
      for (int k = 0; k < int'(VECS[v].nb); k++) begin
        logic [7:0] a;
        a = VECS[v].addr + 8'(k);
        spi_bits(VECS[v].seed + 8'(k * 17), 8, rx);
        if (VECS[v].cmd == 8'h03)
          chk((k == 0) ? "R4 read byte" : "R5 read burst byte", 32'(rx), 32'(shadow[a]));
      end
      sel_off();
      chk("R9 sdo stable while sclk high", 32'(glitch), 0);
      chk("R9 sdo low after deselect", 32'(sdo), 0);
      if (VECS[v].cmd == 8'h02) begin
        chk("R2 write count", 32'(log_n - base), 32'(VECS[v].nb));
        for (int k = 0; k < int'(VECS[v].nb); k++) begin
          logic [7:0] a;
          a = VECS[v].addr + 8'(k);
          chk("R3 burst write addr", 32'(log_a[base + k]), 32'(a));
          chk("R2 write data", 32'(log_d[base + k]), 32'(VECS[v].seed + 8'(k * 17)));
          shadow[a] = VECS[v].seed + 8'(k * 17);
        end
      end else if (VECS[v].cmd == 8'h03) begin
        chk("R8 no write during read", 32'(log_n - base), 0);
      end else begin
        chk("R6 no write on bad opcode", 32'(log_n - base), 0);
        chk("R6 sdo silent on bad opcode", 32'(sdo_any), 0);
      end
    end

    // R7: one full byte then a 5-bit fragment
    base = log_n;
    sel_on();
    spi_bits(8'h02, 8, rx);
    spi_bits(8'h30, 8, rx);
    spi_bits(8'h11, 8, rx);
    spi_bits(8'hEE, 5, rx);
    sel_off();
    chk("R7 only complete byte written", 32'(log_n - base), 1);
    chk("R7 complete byte addr", 32'(log_a[base]), 32'h30);
    chk("R7 complete byte data", 32'(log_d[base]), 32'h11);
    shadow[8'h30] = 8'h11;
    sel_on();
    spi_bits(8'h03, 8, rx);
    spi_bits(8'h31, 8, rx);
    spi_bits(8'h00, 8, rx);
    sel_off();
    chk("R7 fragment target unchanged", 32'(rx), 32'(shadow[8'h31]));

    // R10: 3-bit opcode fragment, then a clean write window
    base = log_n;
    sel_on();
    spi_bits(8'h03, 3, rx);
    sel_off();
    sel_on();
    spi_bits(8'h02, 8, rx);
    spi_bits(8'h50, 8, rx);
    spi_bits(8'h77, 8, rx);
    sel_off();
    chk("R10 write after aborted opcode count", 32'(log_n - base), 1);
    chk("R10 write after aborted opcode addr", 32'(log_a[base]), 32'h50);
    chk("R10 write after aborted opcode data", 32'(log_d[base]), 32'h77);

    // R8: read with busy sdi pattern returns the same data
    sel_on();
    spi_bits(8'h03, 8, rx);
    spi_bits(8'h50, 8, rx);
    spi_bits(8'hFF, 8, rx);
    sel_off();
    chk("R8 read with sdi high", 32'(rx), 32'h77);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule